// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit with Rounding and Clamping

This block is a single-cycle multiply-accumulate datapath for signed fractional fixed-point samples. Each operand is `DW` bits wide and represents a value in the range -1 <= x < 1, with the binary point just to the right of the sign bit. On every clock where the strobe is high, the two operands are multiplied at full precision. The product is shifted left by one place so that it has a single sign bit. It is then either loaded into the accumulator or added to or subtracted from it. The accumulator carries `GW` guard bits above the product width, so long sums that pass ±1 are held exactly.

An output stage reduces the accumulator to a `DW`-bit sample. It takes accumulator bits `[AW-1:DW]` as the integer part and applies one of three rounding rules: truncation, round-half-up or round-half-to-even. When clamping is enabled it then pins any out-of-range value to the nearest end of the `DW`-bit range. A sticky flag records that the accumulator has left the single-word range. Typical use is the inner loop of an FIR filter: the first tap of each output sample uses the load control, and the rounded sample is read after the last tap.

Top module: `fxp_mac`

## Requirements
- R1: After a load operation, `acc_o` equals 2·a·b as a sign-extended `AW`-bit integer (`AW` = 2·`DW`+`GW`), with every low-order product bit kept.
- R2: The operand pair a = b = -2^(DW-1) yields the product 2^(2·DW-1)-1 instead of an overflowed value.
- R3: With `in_valid` and `clr` both high, the accumulator takes the new signed product and ignores its previous contents.
- R4: With `in_valid` high and `clr` low, the accumulator adds the product (`sub`=0) or subtracts it (`sub`=1). One operation completes on every clock, and the result appears in the cycle after the strobe.
- R5: Sums whose magnitude exceeds one full-scale product are held exactly in the guard bits, so subtracting the same terms again restores the earlier value bit for bit.
- R6: With `sat_en`=1, a rounded result above 2^(DW-1)-1 gives `res_o` = 2^(DW-1)-1.
- R7: With `sat_en`=1, a rounded result below -2^(DW-1) gives `res_o` = -2^(DW-1).
- R8: With `sat_en`=0, `res_o` is the low `DW` bits of the rounded value, which wraps on overflow.
- R9: `rnd_sel` codes 0 and 3 select truncation: `res_o` is based on floor(acc / 2^DW), where the kept part is `acc_o[AW-1:DW]`.
- R10: `rnd_sel` code 1 selects rounding to nearest. A discarded part below one half rounds down, and a part of exactly one half (bit DW-1 set, lower bits clear) rounds toward the more positive value.
- R11: `rnd_sel` code 2 selects convergent rounding. It acts as in R10 except that an exact half goes to whichever neighbour has a zero least significant bit.
- R12: `ovf_o` is set when an operation leaves accumulator bits `[AW-1:2·DW-1]` not all equal. It stays set until a load operation, which clears it and then sets it again if the loaded value itself overflows.
- R13: While `in_valid` is low, `acc_o` and `ovf_o` hold their values whatever `clr`, `sub` and the operands do.
- R14: Synchronous reset clears the accumulator and the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Performs one operation on this clock |
| op_a | input | DW | Signed fractional operand A |
| op_b | input | DW | Signed fractional operand B |
| clr | input | 1 | Load the product instead of accumulating |
| sub | input | 1 | Negate the product before use |
| rnd_sel | input | 2 | Rounding rule: 0/3 truncate, 1 nearest, 2 convergent |
| sat_en | input | 1 | Clamp the output word instead of wrapping |
| acc_o | output | AW | Full accumulator contents |
| res_o | output | DW | Rounded, optionally clamped output word |
| ovf_o | output | 1 | Sticky accumulator overflow flag |

## Verification
The bench places the accumulator exactly on half-LSB ties, for both positive and negative values and for both odd and even kept parts. A design that mixed up the tie rule, or floored negatives the wrong way, would show up here as a result one code away from the expected value. It also feeds the doubly negative full-scale operand pair, where a plain shift would give a large negative product instead of the positive ceiling. It drives the sum past ±1 and back, so a design without real guard bits would lose the round trip, and one that wrapped instead of clamping would output a sample of the wrong sign. The bench also changes `clr` and `sub` while the strobe is low, and checks that the sticky flag survives the return of the sum into range.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        RND_TRUNC     = 2'd0,
        RND_NEAREST   = 2'd1,
        RND_EVEN      = 2'd2,
        RND_TRUNC_ALT = 2'd3
    } rnd_mode_e;

    typedef struct packed {
        logic load;
        logic neg;
    } acc_ctl_t;

    // Decide whether the kept part is incremented for a given rounding rule.
    function automatic logic round_up(
        input rnd_mode_e mode,
        input logic      kept_lsb,
        input logic      half_bit,
        input logic      below_half
    );
        logic up;
        case (mode)
            RND_NEAREST: up = half_bit;
            RND_EVEN:    up = half_bit & (below_half | kept_lsb);
            default:     up = 1'b0;
        endcase
        return up;
    endfunction

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [2*DW-1:0] prod
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;
    logic signed [PW-1:0] raw;
    logic                 both_min;

    always_comb begin
        a_ext    = {{DW{a[DW-1]}}, a};
        b_ext    = {{DW{b[DW-1]}}, b};
        raw      = a_ext * b_ext;
        both_min = (a == {1'b1, {(DW-1){1'b0}}}) && (b == {1'b1, {(DW-1){1'b0}}});
        // Drop the duplicate sign bit; -1 x -1 is the one case it carries data.
        prod     = both_min ? {1'b0, {(PW-1){1'b1}}} : {raw[PW-2:0], 1'b0};
    end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
#(
    parameter int DW = 16,
    parameter int GW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid,
    input  acc_ctl_t             ctl,
    input  logic [2*DW-1:0]      prod,
    output logic [2*DW+GW-1:0]   acc,
    output logic                 ovf
);
    localparam int PW = 2 * DW;
    localparam int AW = PW + GW;
    localparam int TW = GW + 1;

    logic [AW-1:0] ext;
    logic [AW-1:0] addend;
    logic [AW-1:0] start;
    logic [AW-1:0] nxt;
    logic [TW-1:0] top;
    logic          guard_bad;

    always_comb begin
        ext       = {{GW{prod[PW-1]}}, prod};
        addend    = ctl.neg ? (~ext + 1'b1) : ext;
        start     = ctl.load ? '0 : acc;
        nxt       = start + addend;
        top       = nxt[AW-1:PW-1];
        guard_bad = !((&top) || !(|top));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            ovf <= 1'b0;
        end else if (valid) begin
            acc <= nxt;
            ovf <= (ovf & ~ctl.load) | guard_bad;
        end
    end
endmodule

// File: rtl/mac_round_sat.sv
module mac_round_sat
    import mac_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic [AW-1:0] acc,
    input  rnd_mode_e     mode,
    input  logic          sat_en,
    output logic [DW-1:0] res
);
    localparam int RW = AW - DW + 1;

    logic [RW-1:0]    kept;
    logic [RW-1:0]    rnd;
    logic             up;
    logic [RW-DW:0]   hi;
    logic             fits;

    always_comb begin
        kept = {acc[AW-1], acc[AW-1:DW]};
        up   = round_up(mode, acc[DW], acc[DW-1], |acc[DW-2:0]);
        rnd  = kept + {{(RW-1){1'b0}}, up};
        hi   = rnd[RW-1:DW-1];
        fits = (&hi) || !(|hi);
        if (fits || !sat_en)
            res = rnd[DW-1:0];
        else if (rnd[RW-1])
            res = {1'b1, {(DW-1){1'b0}}};
        else
            res = {1'b0, {(DW-1){1'b1}}};
    end
endmodule

// File: rtl/fxp_mac.sv
module fxp_mac
    import mac_pkg::*;
#(
    parameter int DW = 16,
    parameter int GW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [DW-1:0]        op_a,
    input  logic [DW-1:0]        op_b,
    input  logic                 clr,
    input  logic                 sub,
    input  logic [1:0]           rnd_sel,
    input  logic                 sat_en,
    output logic [2*DW+GW-1:0]   acc_o,
    output logic [DW-1:0]        res_o,
    output logic                 ovf_o
);
    localparam int AW = 2 * DW + GW;

    logic [2*DW-1:0] prod;
    acc_ctl_t        ctl;

    assign ctl.load = clr;
    assign ctl.neg  = sub;

    mac_mult #(.DW(DW)) u_mult (
        .a    (op_a),
        .b    (op_b),
        .prod (prod)
    );

    mac_accum #(.DW(DW), .GW(GW)) u_accum (
        .clk   (clk),
        .rst   (rst),
        .valid (in_valid),
        .ctl   (ctl),
        .prod  (prod),
        .acc   (acc_o),
        .ovf   (ovf_o)
    );

    mac_round_sat #(.DW(DW), .AW(AW)) u_out (
        .acc    (acc_o),
        .mode   (rnd_mode_e'(rnd_sel)),
        .sat_en (sat_en),
        .res    (res_o)
    );
endmodule

// File: rtl/mac_chk.sv
module mac_chk #(
    parameter int DW = 16,
    parameter int GW = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [DW-1:0]        op_a,
    input logic [DW-1:0]        op_b,
    input logic                 clr,
    input logic                 sub,
    input logic                 sat_en,
    input logic [2*DW+GW-1:0]   acc_o,
    input logic [DW-1:0]        res_o,
    input logic                 ovf_o
);
    localparam int AW = 2 * DW + GW;
    localparam logic [DW-1:0] W_MIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] W_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [AW-1:0] P_MAX = {{(GW+1){1'b0}}, {(2*DW-1){1'b1}}};

    a_r14_reset_clears: assert property (@(posedge clk)
        rst |=> (acc_o == '0 && !ovf_o));

    a_r13_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(acc_o) && $stable(ovf_o)));

    a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !(in_valid && clr)) |=> ovf_o);

    a_r2_min_squared: assert property (@(posedge clk) disable iff (rst)
        (in_valid && clr && !sub && op_a == W_MIN && op_b == W_MIN) |=> acc_o == P_MAX);

    a_r3_load_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && clr && op_a == '0) |=> acc_o == '0);

    a_r6_clamp_high: assert property (@(posedge clk) disable iff (rst)
        (sat_en && !acc_o[AW-1] && acc_o[AW-1:2*DW-1] != '0) |-> res_o == W_MAX);

    a_r7_clamp_low: assert property (@(posedge clk) disable iff (rst)
        (sat_en && acc_o[AW-1] && !(&acc_o[AW-1:2*DW-1])) |-> res_o == W_MIN);
endmodule

bind fxp_mac mac_chk #(.DW(DW), .GW(GW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .clr      (clr),
    .sub      (sub),
    .sat_en   (sat_en),
    .acc_o    (acc_o),
    .res_o    (res_o),
    .ovf_o    (ovf_o)
);

// File: tb/test_fxp_mac.sv
module test_fxp_mac;
    localparam int DW = 16;
    localparam int GW = 8;
    localparam int AW = 2 * DW + GW;

    typedef struct {
        logic [AW-1:0] acc;
        logic [DW-1:0] res;
        logic          ovf;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] op_a = '0;
    logic [DW-1:0] op_b = '0;
    logic          clr = 1'b0;
    logic          sub = 1'b0;
    logic [1:0]    rnd_sel = 2'd0;
    logic          sat_en = 1'b0;
    logic [AW-1:0] acc_o;
    logic [DW-1:0] res_o;
    logic          ovf_o;
    logic          tb_chk = 1'b0;

    int     n_chk = 0;
    int     n_err = 0;
    longint acc_m = 0;
    bit     ovf_m = 1'b0;
    exp_t   sb_q[$];

    always #2 clk = ~clk;

    fxp_mac #(.DW(DW), .GW(GW)) i_fxp_mac (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .clr(clr), .sub(sub), .rnd_sel(rnd_sel), .sat_en(sat_en),
        .acc_o(acc_o), .res_o(res_o), .ovf_o(ovf_o)
    );

    function automatic longint frac_mul(input int a, input int b);
        if (a == -32768 && b == -32768) return 64'sd2147483647;
        return longint'(a) * longint'(b) * 2;
    endfunction

    function automatic logic [DW-1:0] word_model(input longint acc, input int m, input bit sat);
        longint base;
        longint low;
        longint r;
        bit     up;
        base = acc >>> 16;
        low  = acc & 64'sh0000_0000_0000_FFFF;
        case (m)
            1:       up = (low >= 32768);
            2:       up = (low > 32768) || (low == 32768 && base[0]);
            default: up = 1'b0;
        endcase
        r = base + longint'(up);
        if (r > 32767)  return sat ? 16'h7FFF : r[15:0];
        if (r < -32768) return sat ? 16'h8000 : r[15:0];
        return r[15:0];
    endfunction

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and records what must come out.
    task automatic drive(input bit v, input bit c, input bit s, input int a, input int b,
                         input int m, input bit sat, input string tag);
        exp_t   e;
        longint p;
        @(negedge clk);
        in_valid = v; clr = c; sub = s;
        op_a = a[15:0]; op_b = b[15:0];
        rnd_sel = m[1:0]; sat_en = sat; tb_chk = 1'b1;
        if (v) begin
            p = frac_mul(a, b);
            if (s) p = -p;
            acc_m = c ? p : acc_m + p;
            ovf_m = (c ? 1'b0 : ovf_m) |
                    ((acc_m > 64'sd2147483647) || (acc_m < -64'sd2147483648));
        end
        e.acc = acc_m[AW-1:0];
        e.res = word_model(acc_m, m, sat);
        e.ovf = ovf_m;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; tb_chk = 1'b0;
    endtask

    // Monitor: after each checked edge, compares the design with the oldest entry.
    always @(posedge clk) begin
        if (tb_chk) begin
            #1;
            if (sb_q.size() == 0) begin
                check(1'b0, "scoreboard empty", 0, 1);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(acc_o == e.acc, {e.tag, " acc"}, longint'(acc_o), longint'(e.acc));
                check(res_o == e.res, {e.tag, " res"}, longint'(res_o), longint'(e.res));
                check(ovf_o == e.ovf, {e.tag, " ovf"}, longint'(ovf_o), longint'(e.ovf));
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(acc_o == '0, "R14 reset acc", longint'(acc_o), 0);
        check(ovf_o == 1'b0, "R14 reset ovf", longint'(ovf_o), 0);
        check(res_o == '0, "R14 reset res", longint'(res_o), 0);

        drive(1, 1, 0, 16384, 16384, 0, 1, "R1 half times half");
        drive(1, 1, 0, 3, 5, 0, 1, "R1 low product bits");
        drive(1, 1, 0, -32768, -32768, 0, 1, "R2 minus one squared");
        drive(1, 1, 0, 1000, -2000, 0, 1, "R3 load ignores old");
        drive(1, 0, 0, 1234, 567, 1, 1, "R4 add");
        drive(1, 0, 1, 300, -400, 1, 1, "R4 subtract");
        drive(1, 0, 0, -32768, 100, 2, 1, "R4 back to back");
        drive(0, 1, 1, 9999, 9999, 2, 1, "R13 idle with clear");
        drive(0, 0, 0, -5, 7, 0, 1, "R13 idle with operands");

        drive(1, 1, 0, 1, 16384, 1, 1, "R10 positive half up");
        drive(0, 0, 0, 0, 0, 2, 1, "R11 half to even zero");
        drive(0, 0, 0, 0, 0, 0, 1, "R9 truncate code 0");
        drive(0, 0, 0, 0, 0, 3, 1, "R9 truncate code 3");
        drive(1, 1, 0, 3, 16384, 2, 1, "R11 odd half goes up");
        drive(0, 0, 0, 0, 0, 1, 1, "R10 odd half up");
        drive(1, 1, 0, -1, 16384, 1, 1, "R10 negative half up");
        drive(0, 0, 0, 0, 0, 2, 1, "R11 negative half to even");
        drive(0, 0, 0, 0, 0, 0, 1, "R9 negative floor");
        drive(1, 1, 0, -3, 16384, 2, 1, "R11 negative even kept");
        drive(0, 0, 0, 0, 0, 1, 1, "R10 negative half toward plus");
        drive(1, 1, 0, 5, 12345, 1, 1, "R10 above half");
        drive(0, 0, 0, 0, 0, 2, 1, "R11 above half");

        drive(1, 1, 0, 32767, 32767, 1, 1, "R5 load near one");
        for (int i = 0; i < 3; i++)
            drive(1, 0, 0, 32767, 32767, 1, 1, "R6 clamp high");
        drive(0, 0, 0, 0, 0, 0, 0, "R8 wrap positive");
        for (int i = 0; i < 3; i++)
            drive(1, 0, 1, 32767, 32767, 1, 1, "R5 exact return");
        drive(0, 0, 0, 0, 0, 1, 1, "R12 flag stays set");
        drive(1, 1, 0, 100, 100, 0, 1, "R12 load clears flag");

        drive(1, 1, 0, -32768, 32767, 0, 1, "R7 load near minus one");
        drive(1, 0, 0, -32768, 32767, 0, 1, "R7 clamp low");
        drive(0, 0, 0, 0, 0, 0, 0, "R8 wrap negative");
        drive(1, 1, 1, -32768, -32768, 0, 1, "R12 load negated");
        idle();
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R4 all results seen", sb_q.size(), 0);
        summary();
    end
endmodule